// File: doc/BRIEF.md
# Multi-Track Loop Record/Replay Sequencer

This block sequences the record and replay passes of a sixteen-track audio looper. A user selects a track with a 4-bit selector and raises a replay request or a record request. When both are present, replay wins. The sequencer then waits until the audio buffer's bit-edge counter reaches the alignment value, so that each pass starts on a word boundary of the serial buffer. Only then does it start a pass of fixed length, measured in 16-bit words.

During a pass, every word-ready pulse from the buffer produces one memory request. Record passes issue writes and replay passes issue reads. The memory address is the track number, latched when the pass was accepted, joined above a word counter. After the last word the sequencer returns to idle for one cycle. If the request is still held, it starts another pass on the same track, which produces looping.

Top module: `rec_loop_ctrl`

## Requirements
- R1: After reset the sequencer is idle: `play_en`, `rec_en`, `play_led`, `rec_led`, `mem_req` and `mem_we` are all 0.
- R2: In idle, a replay request is taken in preference to a record request. When both are high, only `play_led` rises, one cycle later.
- R3: After a request is accepted, the matching indicator (`play_led` or `rec_led`) is high. The enables stay low until a cycle in which `edge_cnt` equals `ALIGN`. The matching enable rises one cycle after that cycle.
- R4: During a pass, exactly one of `play_en` and `rec_en` is high, and the matching indicator stays high.
- R5: During a pass, each `word_tick` cycle raises `mem_req` in that same cycle. `mem_we` is 1 on a record pass and 0 on a replay pass. There is no request without a tick or outside a pass.
- R6: `mem_addr` is {latched track, word index}. The word index is 0 at the first request of a pass and rises by one per request.
- R7: A pass makes exactly `WORDS` requests. The enable and the indicator fall in the cycle after the last one.
- R8: The track is latched when a request is accepted. Changes on `track_sel` during a pass do not alter `mem_addr`.
- R9: If the request is still high in the idle cycle after a pass, a new pass on the same kind is accepted at once.
- R10: Requests that arrive while a pass or a wait is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track_sel | input | TRK_W | Selected track number |
| play_req | input | 1 | Replay request level |
| rec_req | input | 1 | Record request level |
| edge_cnt | input | EDGE_W | Bit-edge count from the audio buffer |
| word_tick | input | 1 | One-cycle pulse when a buffer word is complete |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | TRK_W+CNT_W | Word address {track, index} |
| play_en | output | 1 | Replay pass active |
| rec_en | output | 1 | Record pass active |
| play_led | output | 1 | Replay indicator (wait and pass) |
| rec_led | output | 1 | Record indicator (wait and pass) |

## Verification
State changes land one clock after the input cycle that causes them. This covers a request being accepted, a wait ending on the alignment count, and a pass ending on its last tick. The memory request and its address are combinational on `word_tick`, so they appear in the same cycle as the tick. The bench drives inputs on the falling edge and compares every output just after that edge against a behavioural model, which it advances on each rising edge. Directed checks wait the exact number of falling edges implied by those latencies before sampling.

// File: rtl/rec_loop_ctrl.sv
module rec_loop_ctrl #(
  parameter int TRACKS = 16,
  parameter int WORDS  = 446428,
  parameter int EDGE_W = 4,
  parameter int ALIGN  = 1,
  localparam int TRK_W  = $clog2(TRACKS),
  localparam int CNT_W  = $clog2(WORDS),
  localparam int ADDR_W = TRK_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRK_W-1:0]  track_sel,
  input  logic              play_req,
  input  logic              rec_req,
  input  logic [EDGE_W-1:0] edge_cnt,
  input  logic              word_tick,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              play_en,
  output logic              rec_en,
  output logic              play_led,
  output logic              rec_led
);
  typedef enum logic [2:0] {IDLE, PWAIT, RWAIT, PLAY, REC} st_t;

  st_t              st;
  logic [TRK_W-1:0] trk;
  logic [CNT_W-1:0] idx;

  wire aligned = (edge_cnt == EDGE_W'(ALIGN));
  wire last    = (idx == CNT_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= IDLE;
      trk <= '0;
      idx <= '0;
    end else begin
      case (st)
        IDLE: begin
          idx <= '0;
          if (play_req) begin
            st  <= PWAIT;
            trk <= track_sel;
          end else if (rec_req) begin
            st  <= RWAIT;
            trk <= track_sel;
          end
        end
        PWAIT: if (aligned) st <= PLAY;
        RWAIT: if (aligned) st <= REC;
        PLAY, REC: if (word_tick) begin
          if (last) begin
            st  <= IDLE;
            idx <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign play_en  = (st == PLAY);
  assign rec_en   = (st == REC);
  assign play_led = play_en | (st == PWAIT);
  assign rec_led  = rec_en | (st == RWAIT);
  assign mem_req  = (play_en | rec_en) & word_tick;
  assign mem_we   = rec_en & word_tick;
  assign mem_addr = {trk, idx};
endmodule

// File: rtl/rec_loop_ctrl_chk.sv
module rec_loop_ctrl_chk #(
  parameter int EDGE_W = 4,
  parameter int ALIGN  = 1,
  parameter int TRK_W  = 4,
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EDGE_W-1:0] edge_cnt,
  input logic              word_tick,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              play_en,
  input logic              rec_en,
  input logic              play_led,
  input logic              rec_led
);
  // R4
  one_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({play_en, rec_en}));

  // R3
  start_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(play_en) || $rose(rec_en)) |-> ($past(edge_cnt) == EDGE_W'(ALIGN)));

  // R5
  req_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((play_en || rec_en) && word_tick));

  // R5
  write_only_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (rec_en && mem_req));

  // R7
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(play_en) || $fell(rec_en)) |-> $past(word_tick));

  // R8
  track_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((play_en && $past(play_en)) || (rec_en && $past(rec_en)))
      |-> $stable(mem_addr[ADDR_W-1 -: TRK_W]));

  // R4
  led_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (play_en |-> play_led) and (rec_en |-> rec_led));
endmodule

bind rec_loop_ctrl rec_loop_ctrl_chk #(
  .EDGE_W(EDGE_W), .ALIGN(ALIGN), .TRK_W(TRK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_cnt(edge_cnt), .word_tick(word_tick),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .play_en(play_en), .rec_en(rec_en), .play_led(play_led), .rec_led(rec_led)
);

// File: tb/test_rec_loop_ctrl.sv
module test_rec_loop_ctrl;
  localparam int WORDS  = 5;
  localparam int TRK_W  = 4;
  localparam int CNT_W  = $clog2(WORDS);
  localparam int ADDR_W = TRK_W + CNT_W;

  logic clk = 0, rst_n = 0;
  logic [TRK_W-1:0] track_sel = 0;
  logic play_req = 0, rec_req = 0;
  logic [3:0] edge_cnt = 0;
  logic word_tick = 0;
  logic mem_req, mem_we, play_en, rec_en, play_led, rec_led;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rec_loop_ctrl #(.WORDS(WORDS)) i_rec_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .track_sel(track_sel), .play_req(play_req),
    .rec_req(rec_req), .edge_cnt(edge_cnt), .word_tick(word_tick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .play_en(play_en), .rec_en(rec_en), .play_led(play_led), .rec_led(rec_led));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // Buffer emulation: edge count advances every 2 cycles, tick at wrap.
  int cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    edge_cnt  <= 4'((cyc / 2) % 16);
    word_tick <= (cyc % 32) == 0;
  end

  // Behavioural model: 0 idle, 1 replay wait, 2 record wait, 3 replay, 4 record
  int mst = 0, midx = 0, mtrk = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; midx = 0; mtrk = 0;
    end else begin
      case (mst)
        0: begin
          midx = 0;
          if (play_req) begin mst = 1; mtrk = track_sel; end
          else if (rec_req) begin mst = 2; mtrk = track_sel; end
        end
        1, 2: if (edge_cnt == 1) mst = mst + 2;
        default: if (word_tick) begin
          if (midx == WORDS - 1) begin mst = 0; midx = 0; end
          else midx++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      automatic bit run = (mst >= 3);
      check(play_en == (mst == 3) && rec_en == (mst == 4), "R4 enables", {play_en, rec_en}, mst);
      check(play_led == (mst == 1 || mst == 3) && rec_led == (mst == 2 || mst == 4),
            "R3 indicators", {play_led, rec_led}, mst);
      check(mem_req == (run && word_tick), "R5 mem_req", mem_req, run && word_tick);
      check(mem_we == (mst == 4 && word_tick), "R5 mem_we", mem_we, mst == 4 && word_tick);
      check(mem_addr == ADDR_W'((mtrk << CNT_W) | midx), "R6 mem_addr", mem_addr,
            (mtrk << CNT_W) | midx);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1
    check(!play_en && !rec_en && !play_led && !rec_led && !mem_req && !mem_we,
          "R1 reset", {play_en, rec_en, play_led, rec_led, mem_req, mem_we}, 0);
    @(negedge clk); rst_n = 1;
    step(1);
    check(!play_led && !rec_led, "R1 idle after reset", {play_led, rec_led}, 0);

    // R2: both requests, replay wins
    @(negedge clk); track_sel = 3; play_req = 1; rec_req = 1;
    step(1);
    check(play_led && !rec_led, "R2 priority", {play_led, rec_led}, 2);
    check(!play_en, "R3 no enable during wait", play_en, 0);
    @(negedge clk); rec_req = 0;
    while (!play_en) @(negedge clk);
    #2;
    // R8 and R10: change switches and record request mid pass
    track_sel = 9; rec_req = 1;
    begin
      int reqs = 0;
      while (play_en) begin
        if (mem_req) begin
          check(mem_addr[ADDR_W-1 -: TRK_W] == 3, "R8 latched track", mem_addr[ADDR_W-1 -: TRK_W], 3);
          check(mem_addr[CNT_W-1:0] == reqs, "R6 word index", mem_addr[CNT_W-1:0], reqs);
          reqs++;
        end
        check(!rec_led, "R10 record ignored in pass", rec_led, 0);
        @(negedge clk); #2;
      end
      check(reqs == WORDS, "R7 requests per pass", reqs, WORDS);
    end
    // R9: replay still held, new pass taken after one idle cycle
    step(1);
    check(play_led && !rec_led, "R9 loop restart", {play_led, rec_led}, 2);
    @(negedge clk); play_req = 0;
    while (play_led) @(negedge clk);
    #2;
    // now in idle with rec_req=1 and track 9 -> record pass follows
    step(1);
    check(rec_led, "R2 record when no replay", rec_led, 1);
    rec_req = 0;
    while (!rec_en) @(negedge clk);
    #2;
    check(mem_addr[ADDR_W-1 -: TRK_W] == 9, "R8 track for record", mem_addr[ADDR_W-1 -: TRK_W], 9);
    while (!mem_req) begin @(negedge clk); #2; end
    check(mem_we, "R5 write on record", mem_we, 1);
    while (rec_en) @(negedge clk);
    #2;
    step(2);
    check(!rec_led && !play_led, "R7 idle after last pass", {play_led, rec_led}, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule